// File: doc/BRIEF.md
# External Bus Strobe Timing Generator

This block generates the two strobes of a multiplexed external memory bus for an 8-bit controller core. One strobe latches the low address byte (here `ale_o`). The other is the read strobe for external program memory (here `psen_o`). Both are modelled as active-high pulses and are timed from the oscillator clock. The clock is grouped into machine cycles of 12 oscillator periods: six states of two phases each. Address-latch pulses fall in the second phase of states 1 and 4, so they run at one sixth of the oscillator rate.

For every machine cycle the core reports an access kind: internal fetch, external fetch, or external data access. It also reports whether code runs from external memory, whether a table-read (code lookup) instruction is active, and the value of a software bit that turns off the address-latch output. A data access occupies a window of two machine cycles. Across that window the block drops one address-latch pulse and two program-read pulses.

The raw reset pin is qualified before it takes effect. It must be sampled high for two full machine cycles in a row. While the qualified reset is active, both strobes stay low.

Top module: `bus_strobe_gen`

## Requirements
- R1: The internal reset asserts only after `rst_in` has been sampled high on 24 consecutive rising clock edges (two machine cycles). It clears on the first edge that samples `rst_in` low. A shorter high pulse leaves the strobe pattern unchanged.
- R2: While the internal reset is active, `ale_o` and `psen_o` are both 0. After release, `ale_o` is 0 for the first clock of the new cycle and goes high in the second clock, when address-latch output is enabled.
- R3: Number the clocks of a machine cycle 0 to 11. When enabled, `ale_o` is high for exactly one clock at positions 1 and 7. That gives two pulses per cycle, one every 6 clocks.
- R4: `acc_kind` is encoded as 00 = internal fetch, 01 = external fetch, 10 = external data access, 11 = treated as internal fetch. In a cycle of kind 01, `psen_o` is high at positions 3–5 and 9–11. In a cycle of kind 00 or 11, `psen_o` stays low.
- R5: Kind 10 opens a window of two machine cycles. The `acc_kind` value offered at the start of the second cycle is ignored. Within the window, only the pulse at position 1 of the second cycle is dropped from `ale_o`, which leaves 3 pulses.
- R6: In a data window with `ext_exec`=1, the program-read pulse in the second half of the first cycle is dropped. So is the one in the first half of the second cycle, which leaves 6 high clocks. With `ext_exec`=0, no program-read pulse appears in the window.
- R7: With `ale_off`=1, `ale_o` stays low. This does not apply when `ext_exec`=1, when `lookup_op`=1, or when the cycle belongs to a data window; in those cases the pulses of R3 and R5 appear.
- R8: `acc_kind`, `ale_off`, `ext_exec` and `lookup_op` are sampled only on the edge that starts a machine cycle. A change later in the cycle has no effect until the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator clock |
| rst_in | input | 1 | Raw reset pin, active high, qualified internally |
| acc_kind | input | 2 | Access kind for the next machine cycle (see R4) |
| ale_off | input | 1 | Software bit that turns off the address-latch output |
| ext_exec | input | 1 | Code is executing from external program memory |
| lookup_op | input | 1 | A table-read instruction is in progress |
| ale_o | output | 1 | Address latch enable, active high |
| psen_o | output | 1 | Program store enable, active high |

## Verification
Two functions act on the same address-latch slot: the data-window omission and the software disable with its overrides. They can also act on that slot in the same cycle that a new `acc_kind` value is offered at the window boundary. The bench runs data windows with `ale_off` set and `ext_exec` cleared. It changes `acc_kind` immediately after a window opens, so that the second cycle is offered a different kind. A behavioural model decides on every clock which rule governs each strobe. Each comparison is judged against that model, and pulse counts per window are checked as well.

// File: rtl/bstrobe_pkg.sv
package bstrobe_pkg;

  typedef int unsigned uint_t;

  typedef enum logic [1:0] {
    ACC_INT   = 2'b00,
    ACC_EXT   = 2'b01,
    ACC_XDATA = 2'b10,
    ACC_RSV   = 2'b11
  } acc_kind_e;

  // Context captured at the start of each machine cycle.
  typedef struct packed {
    acc_kind_e kind;
    logic      second;   // second cycle of a data window
    logic      ext;
    logic      ale_off;
    logic      lookup;
  } cyc_ctx_t;

  // Position of a clock inside its half machine cycle.
  function automatic uint_t pos_in_half(input uint_t ph, input uint_t half_len);
    return ph % half_len;
  endfunction

  function automatic logic is_late_half(input uint_t ph, input uint_t half_len);
    return ph >= half_len;
  endfunction

  function automatic logic is_ale_slot(input uint_t ph, input uint_t half_len,
                                       input uint_t ale_pos);
    return pos_in_half(ph, half_len) == ale_pos;
  endfunction

  function automatic logic is_psen_slot(input uint_t ph, input uint_t half_len,
                                        input uint_t psen_first);
    return pos_in_half(ph, half_len) >= psen_first;
  endfunction

endpackage

// File: rtl/bstrobe_rst_qual.sv
module bstrobe_rst_qual #(
  parameter int unsigned HOLD_CLKS = 24
) (
  input  logic clk,
  input  logic rst_in,
  output logic core_rst
);
  localparam int unsigned RUN_W = $clog2(HOLD_CLKS + 1);

  logic [RUN_W-1:0] run_q;

  always_ff @(posedge clk) begin
    if (!rst_in) begin
      run_q    <= '0;
      core_rst <= 1'b0;
    end else begin
      if (run_q != RUN_W'(HOLD_CLKS)) run_q <= run_q + 1'b1;
      if (run_q >= RUN_W'(HOLD_CLKS - 1)) core_rst <= 1'b1;
    end
  end
endmodule

// File: rtl/bstrobe_sequencer.sv
module bstrobe_sequencer
  import bstrobe_pkg::*;
#(
  parameter int unsigned CYC_CLKS = 12
) (
  input  logic                        clk,
  input  logic                        core_rst,
  input  logic [1:0]                  acc_kind,
  input  logic                        ale_off,
  input  logic                        ext_exec,
  input  logic                        lookup_op,
  output logic [$clog2(CYC_CLKS)-1:0] ph,
  output cyc_ctx_t                    ctx,
  output logic                        cyc_start
);
  localparam int unsigned PH_W = $clog2(CYC_CLKS);
  localparam int unsigned LAST = CYC_CLKS - 1;

  cyc_ctx_t nxt;

  assign cyc_start = core_rst || (ph == PH_W'(LAST));

  always_comb begin
    nxt.ale_off = ale_off;
    nxt.ext     = ext_exec;
    nxt.lookup  = lookup_op;
    if (!core_rst && ctx.kind == ACC_XDATA && !ctx.second) begin
      nxt.kind   = ACC_XDATA;
      nxt.second = 1'b1;
    end else begin
      nxt.kind   = (acc_kind == 2'b11) ? ACC_INT : acc_kind_e'(acc_kind);
      nxt.second = 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (cyc_start) begin
      ph  <= '0;
      ctx <= nxt;
    end else begin
      ph  <= ph + 1'b1;
    end
  end
endmodule

// File: rtl/bstrobe_shaper.sv
module bstrobe_shaper
  import bstrobe_pkg::*;
#(
  parameter int unsigned CYC_CLKS   = 12,
  parameter int unsigned ALE_POS    = 1,
  parameter int unsigned PSEN_FIRST = 3
) (
  input  logic                        core_rst,
  input  logic [$clog2(CYC_CLKS)-1:0] ph,
  input  cyc_ctx_t                    ctx,
  output logic                        ale_o,
  output logic                        psen_o
);
  localparam int unsigned HALF = CYC_CLKS / 2;

  logic late, in_win, ale_slot, psen_slot;
  logic ale_en, psen_en, ale_drop, psen_drop;

  always_comb begin
    late      = is_late_half(uint_t'(ph), HALF);
    ale_slot  = is_ale_slot(uint_t'(ph), HALF, ALE_POS);
    psen_slot = is_psen_slot(uint_t'(ph), HALF, PSEN_FIRST);
    in_win    = (ctx.kind == ACC_XDATA);
    ale_en    = !ctx.ale_off || ctx.ext || ctx.lookup || in_win;
    psen_en   = (ctx.kind == ACC_EXT) || (in_win && ctx.ext);
    ale_drop  = in_win && ctx.second && !late;
    psen_drop = in_win && (ctx.second ^ late);
    ale_o     = !core_rst && ale_slot && ale_en && !ale_drop;
    psen_o    = !core_rst && psen_slot && psen_en && !psen_drop;
  end
endmodule

// File: rtl/bus_strobe_gen.sv
module bus_strobe_gen
  import bstrobe_pkg::*;
#(
  parameter int unsigned CYC_CLKS    = 12,
  parameter int unsigned HOLD_CYCLES = 2,
  parameter int unsigned ALE_POS     = 1,
  parameter int unsigned PSEN_FIRST  = 3
) (
  input  logic       clk,
  input  logic       rst_in,
  input  logic [1:0] acc_kind,
  input  logic       ale_off,
  input  logic       ext_exec,
  input  logic       lookup_op,
  output logic       ale_o,
  output logic       psen_o
);
  localparam int unsigned HOLD_CLKS = CYC_CLKS * HOLD_CYCLES;
  localparam int unsigned PH_W      = $clog2(CYC_CLKS);

  logic            core_rst;
  logic [PH_W-1:0] ph;
  cyc_ctx_t        ctx;
  logic            cyc_start;

  bstrobe_rst_qual #(.HOLD_CLKS(HOLD_CLKS)) u_qual (
    .clk(clk), .rst_in(rst_in), .core_rst(core_rst)
  );

  bstrobe_sequencer #(.CYC_CLKS(CYC_CLKS)) u_seq (
    .clk(clk), .core_rst(core_rst), .acc_kind(acc_kind), .ale_off(ale_off),
    .ext_exec(ext_exec), .lookup_op(lookup_op), .ph(ph), .ctx(ctx),
    .cyc_start(cyc_start)
  );

  bstrobe_shaper #(.CYC_CLKS(CYC_CLKS), .ALE_POS(ALE_POS), .PSEN_FIRST(PSEN_FIRST)) u_shp (
    .core_rst(core_rst), .ph(ph), .ctx(ctx), .ale_o(ale_o), .psen_o(psen_o)
  );
endmodule

// File: rtl/bstrobe_checker.sv
module bstrobe_checker #(
  parameter int unsigned CYC_CLKS    = 12,
  parameter int unsigned HOLD_CYCLES = 2,
  parameter int unsigned ALE_POS     = 1,
  parameter int unsigned PSEN_FIRST  = 3
) (
  input logic                        clk,
  input logic                        rst_in,
  input logic                        core_rst,
  input logic [$clog2(CYC_CLKS)-1:0] ph,
  input logic [1:0]                  kind,
  input logic                        second,
  input logic                        ext,
  input logic                        ale_off,
  input logic                        lookup,
  input logic                        cyc_start,
  input logic                        ale_o,
  input logic                        psen_o
);
  localparam int unsigned HOLD = CYC_CLKS * HOLD_CYCLES;
  localparam int unsigned HALF = CYC_CLKS / 2;
  localparam int unsigned PH_W = $clog2(CYC_CLKS);
  localparam int unsigned RW   = $clog2(HOLD + 1);

  logic [RW-1:0] hi_run;
  always_ff @(posedge clk) begin
    if (!rst_in) hi_run <= '0;
    else if (hi_run != RW'(HOLD)) hi_run <= hi_run + 1'b1;
  end

  // R1: internal reset only after a full qualification run
  assert_rst_qualified_R1: assert property (@(posedge clk) disable iff (1'b0)
    $rose(core_rst) |-> (hi_run == RW'(HOLD)));
  // R1: a low sample clears the internal reset
  assert_rst_release_R1: assert property (@(posedge clk) disable iff (1'b0)
    !rst_in |=> !core_rst);
  // R2
  assert_quiet_in_reset_R2: assert property (@(posedge clk) disable iff (1'b0)
    core_rst |-> (!ale_o && !psen_o));
  // R3
  assert_ale_position_R3: assert property (@(posedge clk) disable iff (core_rst)
    ale_o |-> (ph == PH_W'(ALE_POS) || ph == PH_W'(HALF + ALE_POS)));
  assert_ale_width_R3: assert property (@(posedge clk) disable iff (core_rst)
    ale_o |=> !ale_o);
  assert_phase_step_R3: assert property (@(posedge clk) disable iff (core_rst)
    !cyc_start |=> (ph == $past(ph) + 1'b1));
  // R4
  assert_psen_kind_R4: assert property (@(posedge clk) disable iff (core_rst)
    psen_o |-> (kind == 2'b01 || (kind == 2'b10 && ext)));
  // R5
  assert_window_second_R5: assert property (@(posedge clk) disable iff (core_rst)
    (kind == 2'b10 && !second && cyc_start) |=> (kind == 2'b10 && second));
  assert_ale_dropped_R5: assert property (@(posedge clk) disable iff (core_rst)
    (kind == 2'b10 && second && ph == PH_W'(ALE_POS)) |-> !ale_o);
  // R6
  assert_psen_dropped_R6: assert property (@(posedge clk) disable iff (core_rst)
    (kind == 2'b10 && (second ? (ph < PH_W'(HALF)) : (ph >= PH_W'(HALF)))) |-> !psen_o);
  // R7
  assert_ale_disabled_R7: assert property (@(posedge clk) disable iff (core_rst)
    (ale_off && !ext && !lookup && kind != 2'b10) |-> !ale_o);
  // R8
  assert_ctx_held_R8: assert property (@(posedge clk) disable iff (core_rst)
    !cyc_start |=> ($stable(kind) && $stable(ext) && $stable(ale_off) && $stable(lookup)));
endmodule

bind bus_strobe_gen bstrobe_checker #(
  .CYC_CLKS(CYC_CLKS), .HOLD_CYCLES(HOLD_CYCLES), .ALE_POS(ALE_POS), .PSEN_FIRST(PSEN_FIRST)
) u_chk (
  .clk(clk), .rst_in(rst_in), .core_rst(core_rst), .ph(ph),
  .kind(ctx.kind), .second(ctx.second), .ext(ctx.ext), .ale_off(ctx.ale_off),
  .lookup(ctx.lookup), .cyc_start(cyc_start), .ale_o(ale_o), .psen_o(psen_o)
);

// File: tb/tb_bus_strobe_gen.sv
module tb_bus_strobe_gen;
  logic clk = 1'b0;
  logic rst_in, ale_off, ext_exec, lookup_op;
  logic [1:0] acc_kind;
  logic ale_o, psen_o;

  int n_chk = 0, n_bad = 0, n_clk = 0;
  bit finished = 0, armed = 0;

  always #2 clk = ~clk;   // 250 MHz

  bus_strobe_gen dut (
    .clk(clk), .rst_in(rst_in), .acc_kind(acc_kind), .ale_off(ale_off),
    .ext_exec(ext_exec), .lookup_op(lookup_op), .ale_o(ale_o), .psen_o(psen_o)
  );

  // ---------------- behavioural reference ----------------
  int m_run = 0, m_k = 0, m_kind = 0;
  bit m_rst = 0, m_second = 0, m_ext = 0, m_off = 0, m_look = 0;

  always @(posedge clk) begin
    bit was_rst;
    was_rst = m_rst;
    if (rst_in) begin
      if (m_run < 24) m_run++;
      if (m_run >= 24) m_rst = 1;
    end else begin
      m_run = 0;
      m_rst = 0;
    end
    if (was_rst || m_k == 11) begin
      if (!was_rst && m_kind == 2 && !m_second) m_second = 1;
      else begin
        m_kind = (acc_kind == 2'd3) ? 0 : int'(acc_kind);
        m_second = 0;
      end
      m_ext = ext_exec; m_off = ale_off; m_look = lookup_op;
      m_k = 0;
    end else m_k++;
    if (m_rst) armed = 1;
    n_clk++;
  end

  function automatic bit exp_ale();
    bit on, skip;
    on   = !m_off || m_ext || m_look || m_kind == 2;
    skip = (m_kind == 2) && m_second && m_k < 6;
    return !m_rst && (m_k % 6 == 1) && on && !skip;
  endfunction

  function automatic bit exp_psen();
    bit on, skip;
    on   = (m_kind == 1) || (m_kind == 2 && m_ext);
    skip = (m_kind == 2) && (m_second ? (m_k < 6) : (m_k >= 6));
    return !m_rst && (m_k % 6 >= 3) && on && !skip;
  endfunction

  task automatic chk(input string tag, input int act, input int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d at clk %0d", tag, act, exp, n_clk);
    end
  endtask

  // per-clock comparison against the model
  always @(negedge clk) begin
    if (armed && !finished) begin
      string ta, tp;
      if (rst_in && !m_rst) begin ta = "R1 ale"; tp = "R1 psen"; end
      else if (m_rst) begin ta = "R2 ale"; tp = "R2 psen"; end
      else begin
        ta = (m_kind == 2) ? "R5 ale" : (m_off ? "R7 ale" : "R3 ale");
        tp = (m_kind == 2) ? "R6 psen" : "R4 psen";
      end
      chk(ta, int'(ale_o), int'(exp_ale()));
      chk(tp, int'(psen_o), int'(exp_psen()));
    end
  end

  // ---------------- directed helpers ----------------
  task automatic wait_k0();
    do @(negedge clk); while (m_k != 0);
  endtask

  task automatic count_strobes(input int n, output int na, output int np);
    na = 0; np = 0;
    for (int i = 0; i < n; i++) begin
      na += int'(ale_o);
      np += int'(psen_o);
      @(negedge clk);
    end
  endtask

  task automatic setup(input logic [1:0] k, input logic off, input logic ex, input logic lk);
    acc_kind = k; ale_off = off; ext_exec = ex; lookup_op = lk;
  endtask

  // ---------------- stimulus ----------------
  initial begin
    int na, np;
    rst_in = 1'b1;
    setup(2'b01, 1'b0, 1'b1, 1'b0);
    repeat (24) @(negedge clk);
    // R2: reset active, strobes silent over a full cycle
    count_strobes(12, na, np);
    chk("R2 ale in reset", na, 0);
    chk("R2 psen in reset", np, 0);
    // R2: release timing
    rst_in = 1'b0;
    @(negedge clk); chk("R2 ale first clock", int'(ale_o), 0);
    @(negedge clk); chk("R2 ale second clock", int'(ale_o), 1);
    // R3/R4: external fetch
    wait_k0(); count_strobes(12, na, np);
    chk("R3 ale per cycle", na, 2);
    chk("R4 psen clocks ext fetch", np, 6);
    // R4: internal fetch and reserved code
    setup(2'b00, 1'b0, 1'b0, 1'b0); wait_k0(); count_strobes(12, na, np);
    chk("R4 psen internal", np, 0); chk("R3 ale internal", na, 2);
    setup(2'b11, 1'b0, 1'b1, 1'b0); wait_k0(); count_strobes(12, na, np);
    chk("R4 psen code 11", np, 0);
    // R5/R6: data window, external code, second-cycle kind ignored
    setup(2'b10, 1'b0, 1'b1, 1'b0); wait_k0();
    acc_kind = 2'b01;
    count_strobes(24, na, np);
    chk("R5 ale in window", na, 3);
    chk("R6 psen in window ext", np, 6);
    // R6: data window, internal code
    setup(2'b10, 1'b0, 1'b0, 1'b0); wait_k0();
    acc_kind = 2'b00;
    count_strobes(24, na, np);
    chk("R6 psen in window int", np, 0);
    chk("R5 ale window int", na, 3);
    // R7: software disable and its overrides
    setup(2'b00, 1'b1, 1'b0, 1'b0); wait_k0(); count_strobes(12, na, np);
    chk("R7 ale disabled", na, 0);
    setup(2'b00, 1'b1, 1'b0, 1'b1); wait_k0(); count_strobes(12, na, np);
    chk("R7 ale lookup override", na, 2);
    setup(2'b01, 1'b1, 1'b1, 1'b0); wait_k0(); count_strobes(12, na, np);
    chk("R7 ale ext override", na, 2);
    setup(2'b10, 1'b1, 1'b0, 1'b0); wait_k0();
    acc_kind = 2'b00;
    count_strobes(24, na, np);
    chk("R7 ale window override", na, 3);
    // R8: mid-cycle changes ignored
    setup(2'b01, 1'b0, 1'b1, 1'b0); wait_k0();
    repeat (2) @(negedge clk);
    setup(2'b00, 1'b1, 1'b0, 1'b0);
    count_strobes(10, na, np);
    chk("R8 psen held", np, 6);
    chk("R8 ale held", na, 1);
    // R1: short reset pulse has no effect
    setup(2'b01, 1'b0, 1'b1, 1'b0); wait_k0();
    rst_in = 1'b1;
    count_strobes(12, na, np);
    chk("R1 psen during short pulse", np, 6);
    repeat (11) @(negedge clk);
    rst_in = 1'b0;
    wait_k0(); count_strobes(12, na, np);
    chk("R1 ale after short pulse", na, 2);
    // R1: exactly 24 high samples qualify
    rst_in = 1'b1;
    repeat (24) @(negedge clk);
    chk("R1 qualified reset silences psen", int'(psen_o), 0);
    rst_in = 1'b0;
    repeat (30) @(negedge clk);
    finished = 1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  // watchdog
  always @(posedge clk) begin
    if (n_clk > 100000 && !finished) begin
      finished = 1;
      n_chk++; n_bad++;
      $display("FAIL watchdog actual=%0d expected=0", n_clk);
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule